// File: doc/BRIEF.md
# Bidirectional Dual-Pixel Sampling Shift Register

This block sits at the input of a display column driver. It takes two RGB pixels on every rising clock edge. Each colour is 8 bits wide, and each pixel also carries a one-bit data-inversion flag. The block writes both pixels into a sampling memory of 128 pixel positions. The A-side pixel always lands on an odd position and the B-side pixel on the following even position. A full line therefore takes 64 capture clocks.

A start pulse begins a sweep. When the last pair has been captured, the block sends a one-clock pulse to the next driver in a chain. A direction input sets the sweep order: ascending with colours in X, Y, Z order, or descending with the colour order inside each pixel mirrored. The same input chooses which of two bidirectional pins is the start input and which is the cascade output. Each pin is modelled as an input, an output and an output-enable.

A read port lets the downstream hold stage look up any stored position. The stored position numbers below are 0-based: 1-based position p is stored at index p-1.

The controller has three named states:
- `ST_IDLE` waits for a start pulse.
- `ST_SAMPLE` captures one pair on every edge.
- `ST_DONE` is the single cycle after the final capture, which loads the cascade pulse.

The transitions are:
- IDLE to SAMPLE on a start pulse.
- SAMPLE to SAMPLE while the pair pointer has not reached its last value.
- SAMPLE to DONE on the capture of the last pair.
- DONE to IDLE unconditionally.
- Any state to IDLE on synchronous reset.

Top module: `dual_pixel_sampler`

## Requirements
- R1: After a synchronous reset the block is in `ST_IDLE`, both pin outputs are low, and no capture takes place until a start pulse is seen.
- R2: Every capture edge writes two pixels. The A pixel goes to an even storage index (odd 1-based position) and the B pixel to the index just above it. 64 captures cover all 128 positions.
- R3: A start pulse seen high at a rising edge in `ST_IDLE` begins a sweep. The first pair is captured on the next rising edge.
- R4: With the direction latched high, capture k (k = 0..63) writes the A pixel to index 2k and the B pixel to index 2k+1. Colour slots X, Y and Z take ports xa/xb, ya/yb and za/zb.
- R5: With the direction latched low, capture k writes the A pixel to index 126-2k and the B pixel to index 127-2k. The colour order is mirrored: slot X takes the z port, slot Z takes the x port, and slot Y takes the y port.
- R6: The inversion flag stored with each A pixel is `pol_a`, and the flag stored with each B pixel is `pol_b`. Both are sampled on the same edge as the data.
- R7: Pin roles follow the live direction input. When dir=1, the left pin is the start input (`pin_l_oe`=0) and the right pin drives the cascade (`pin_r_oe`=1). When dir=0, the roles swap. A pin that is not enabled outputs 0.
- R8: The cascade output goes high after the edge that follows the final capture, and it stays high for exactly one clock period.
- R9: A start pulse that arrives during `ST_SAMPLE` or `ST_DONE` has no effect on the pointer, the stored data or the cascade timing.
- R10: While idle, the sampling memory keeps its contents whatever the data and polarity ports do, and no cascade pulse appears.
- R11: The sweep order is the direction sampled on the start edge. A change of the direction input during a sweep does not change where the remaining pairs are written.
- R12: A synchronous reset during a sweep abandons it with no cascade pulse. The next start begins again at the first pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dir | input | 1 | Sweep direction and pin-role select (1 = ascending) |
| pin_l_in | input | 1 | Left start/cascade pin, input side |
| pin_l_out | output | 1 | Left start/cascade pin, output value |
| pin_l_oe | output | 1 | Left pin output enable |
| pin_r_in | input | 1 | Right start/cascade pin, input side |
| pin_r_out | output | 1 | Right start/cascade pin, output value |
| pin_r_oe | output | 1 | Right pin output enable |
| xa | input | 8 | A pixel, X colour |
| ya | input | 8 | A pixel, Y colour |
| za | input | 8 | A pixel, Z colour |
| pol_a | input | 1 | A pixel inversion flag |
| xb | input | 8 | B pixel, X colour |
| yb | input | 8 | B pixel, Y colour |
| zb | input | 8 | B pixel, Z colour |
| pol_b | input | 1 | B pixel inversion flag |
| rd_pos | input | 7 | Storage index to read |
| rd_x | output | 8 | Stored X colour at rd_pos |
| rd_y | output | 8 | Stored Y colour at rd_pos |
| rd_z | output | 8 | Stored Z colour at rd_pos |
| rd_inv | output | 1 | Stored inversion flag at rd_pos |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- **Descending sweep.** A design that forgot to mirror the colours would show X and Z swapped at every index. A design with an off-by-one base would write past index 127 and leave index 0 stale.
- **Cascade timing.** The pulse must come exactly one edge after the final capture and last one cycle. A pulse that is early, late or stretched shows up on the enabled pin.
- **Start pulses during a sweep and during the cascade cycle.** If they restarted the pointer, earlier positions would be overwritten and the pulse would move.
- **Direction flip mid-sweep.** Flipping the direction partway through would scatter the second half of the line into the wrong half of the memory.
- **Reset mid-sweep.** If a reset left the pointer set, the pairs of the following sweep would be misplaced.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_DONE   = 2'd2
    } dps_state_e;

    localparam int DPS_NCOL = 3;

endpackage

// File: rtl/dps_ctrl.sv
module dps_ctrl
    import dps_pkg::*;
#(
    parameter int PAIRS = 64,
    localparam int PW = $clog2(PAIRS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          dir,
    output logic          cap_en,
    output logic [PW-1:0] ptr,
    output logic          dir_q,
    output logic          casc
);

    localparam logic [PW-1:0] LAST = PW'(PAIRS - 1);

    dps_state_e state, nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_SAMPLE;
            ST_SAMPLE: if (ptr == LAST) nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // pair pointer and latched direction
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            dir_q <= 1'b1;
        end else if (state == ST_IDLE && start) begin
            ptr   <= '0;
            dir_q <= dir;
        end else if (state == ST_SAMPLE) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) casc <= 1'b0;
        else     casc <= (state == ST_DONE);
    end

    assign cap_en = (state == ST_SAMPLE);

    assert_ptr_bound_R2: assert property (@(posedge clk) disable iff (rst)
        32'(ptr) < PAIRS);

    assert_casc_single_R8: assert property (@(posedge clk) disable iff (rst)
        casc |=> !casc);

    assert_casc_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        (cap_en && ptr == LAST) |=> ##1 casc);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (cap_en && ptr != LAST) |=> (cap_en && 32'(ptr) == 32'($past(ptr)) + 1));

    assert_dir_held_R11: assert property (@(posedge clk) disable iff (rst)
        (cap_en && $past(cap_en)) |-> $stable(dir_q));

endmodule

// File: rtl/dps_map.sv
module dps_map
    import dps_pkg::*;
#(
    parameter int COLS = 128,
    parameter int DW   = 8,
    localparam int IW    = $clog2(COLS),
    localparam int PW    = $clog2(COLS / 2),
    localparam int WW    = DPS_NCOL * DW + 1
) (
    input  logic [PW-1:0]                ptr,
    input  logic                         dir_q,
    input  logic [DPS_NCOL-1:0][DW-1:0]  a_pix,
    input  logic                         a_pol,
    input  logic [DPS_NCOL-1:0][DW-1:0]  b_pix,
    input  logic                         b_pol,
    output logic [IW-1:0]                a_idx,
    output logic [IW-1:0]                b_idx,
    output logic [WW-1:0]                a_word,
    output logic [WW-1:0]                b_word
);

    logic [IW-1:0] base;
    assign base  = IW'({ptr, 1'b0});
    assign a_idx = dir_q ? base : IW'(COLS - 2) - base;
    assign b_idx = a_idx + 1'b1;

    logic [DPS_NCOL-1:0][DW-1:0] a_slot, b_slot;

    for (genvar s = 0; s < DPS_NCOL; s++) begin : g_slot
        assign a_slot[s] = dir_q ? a_pix[s] : a_pix[DPS_NCOL-1-s];
        assign b_slot[s] = dir_q ? b_pix[s] : b_pix[DPS_NCOL-1-s];
    end

    assign a_word = {a_pol, a_slot};
    assign b_word = {b_pol, b_slot};

endmodule

// File: rtl/dps_store.sv
module dps_store #(
    parameter int COLS = 128,
    parameter int WW   = 25,
    localparam int IW  = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] a_idx,
    input  logic [WW-1:0] a_word,
    input  logic [IW-1:0] b_idx,
    input  logic [WW-1:0] b_word,
    input  logic [IW-1:0] rd_idx,
    output logic [WW-1:0] rd_word
);

    logic [WW-1:0] mem [COLS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[a_idx] <= a_word;
            mem[b_idx] <= b_word;
        end
    end

    assign rd_word = mem[rd_idx];

    assert_a_written_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(a_idx)] == $past(a_word));

    assert_b_written_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(b_idx)] == $past(b_word));

endmodule

// File: rtl/dual_pixel_sampler.sv
module dual_pixel_sampler
    import dps_pkg::*;
#(
    parameter int COLS = 128,
    parameter int DW   = 8,
    localparam int IW    = $clog2(COLS),
    localparam int PAIRS = COLS / 2,
    localparam int PW    = $clog2(PAIRS),
    localparam int WW    = DPS_NCOL * DW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir,
    input  logic          pin_l_in,
    output logic          pin_l_out,
    output logic          pin_l_oe,
    input  logic          pin_r_in,
    output logic          pin_r_out,
    output logic          pin_r_oe,
    input  logic [DW-1:0] xa,
    input  logic [DW-1:0] ya,
    input  logic [DW-1:0] za,
    input  logic          pol_a,
    input  logic [DW-1:0] xb,
    input  logic [DW-1:0] yb,
    input  logic [DW-1:0] zb,
    input  logic          pol_b,
    input  logic [IW-1:0] rd_pos,
    output logic [DW-1:0] rd_x,
    output logic [DW-1:0] rd_y,
    output logic [DW-1:0] rd_z,
    output logic          rd_inv
);

    logic          start, cap_en, dir_q, casc;
    logic [PW-1:0] ptr;
    logic [IW-1:0] a_idx, b_idx;
    logic [WW-1:0] a_word, b_word, rd_word;

    // pin roles follow the live direction input
    assign start     = dir ? pin_l_in : pin_r_in;
    assign pin_l_oe  = !dir;
    assign pin_r_oe  = dir;
    assign pin_l_out = !dir && casc;
    assign pin_r_out = dir && casc;

    dps_ctrl #(.PAIRS(PAIRS)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .dir    (dir),
        .cap_en (cap_en),
        .ptr    (ptr),
        .dir_q  (dir_q),
        .casc   (casc)
    );

    dps_map #(.COLS(COLS), .DW(DW)) u_map (
        .ptr    (ptr),
        .dir_q  (dir_q),
        .a_pix  ({za, ya, xa}),
        .a_pol  (pol_a),
        .b_pix  ({zb, yb, xb}),
        .b_pol  (pol_b),
        .a_idx  (a_idx),
        .b_idx  (b_idx),
        .a_word (a_word),
        .b_word (b_word)
    );

    dps_store #(.COLS(COLS), .WW(WW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (cap_en),
        .a_idx   (a_idx),
        .a_word  (a_word),
        .b_idx   (b_idx),
        .b_word  (b_word),
        .rd_idx  (rd_pos),
        .rd_word (rd_word)
    );

    assign rd_x   = rd_word[DW-1:0];
    assign rd_y   = rd_word[2*DW-1:DW];
    assign rd_z   = rd_word[3*DW-1:2*DW];
    assign rd_inv = rd_word[WW-1];

    assert_pins_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(pin_l_out && pin_r_out));

    assert_a_pos_odd_R2: assert property (@(posedge clk) disable iff (rst)
        cap_en |-> (!a_idx[0] && b_idx[0]));

endmodule

// File: tb/test_dual_pixel_sampler.sv
module test_dual_pixel_sampler;

    logic       clk = 1'b0;
    logic       rst, dir, pin_l_in, pin_r_in, pol_a, pol_b;
    logic       pin_l_out, pin_l_oe, pin_r_out, pin_r_oe, rd_inv;
    logic [7:0] xa, ya, za, xb, yb, zb, rd_x, rd_y, rd_z;
    logic [6:0] rd_pos;

    int checks = 0;
    int errors = 0;

    logic [7:0] ex [128];
    logic [7:0] ey [128];
    logic [7:0] ez [128];
    logic       ei [128];

    always #5 clk = ~clk;

    dual_pixel_sampler i_dual_pixel_sampler (
        .clk(clk), .rst(rst), .dir(dir),
        .pin_l_in(pin_l_in), .pin_l_out(pin_l_out), .pin_l_oe(pin_l_oe),
        .pin_r_in(pin_r_in), .pin_r_out(pin_r_out), .pin_r_oe(pin_r_oe),
        .xa(xa), .ya(ya), .za(za), .pol_a(pol_a),
        .xb(xb), .yb(yb), .zb(zb), .pol_b(pol_b),
        .rd_pos(rd_pos), .rd_x(rd_x), .rd_y(rd_y), .rd_z(rd_z), .rd_inv(rd_inv)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic casc_pin();
        return dir ? pin_r_out : pin_l_out;
    endfunction

    function automatic int a_index(input bit d, input int k);
        return d ? 2 * k : 126 - 2 * k;
    endfunction

    task automatic rand_data();
        xa = 8'($urandom); ya = 8'($urandom); za = 8'($urandom);
        xb = 8'($urandom); yb = 8'($urandom); zb = 8'($urandom);
        pol_a = 1'($urandom); pol_b = 1'($urandom);
    endtask

    task automatic record(input bit d, input int k);
        int pa = a_index(d, k);
        int pb = pa + 1;
        ex[pa] = d ? xa : za; ey[pa] = ya; ez[pa] = d ? za : xa; ei[pa] = pol_a;
        ex[pb] = d ? xb : zb; ey[pb] = yb; ez[pb] = d ? zb : xb; ei[pb] = pol_b;
    endtask

    task automatic pulse_start();
        if (dir) pin_l_in = 1'b1; else pin_r_in = 1'b1;
    endtask

    task automatic check_mem(input string req);
        for (int p = 0; p < 128; p++) begin
            rd_pos = 7'(p);
            #1;
            chk(req, {rd_inv, rd_z, rd_y, rd_x}, {ei[p], ez[p], ey[p], ex[p]});
        end
        @(negedge clk);
    endtask

    // full sweep; flip_at flips dir mid-sweep, ign_at pulses start mid-sweep,
    // done_start pulses start in the cycle of the DONE state
    task automatic run_sweep(input bit d, input int flip_at, input int ign_at,
                             input bit done_start, input string req);
        dir = d;
        pulse_start();
        @(negedge clk);
        pin_l_in = 1'b0; pin_r_in = 1'b0;
        for (int k = 0; k < 64; k++) begin
            rand_data();
            record(d, k);
            if (k == ign_at) pulse_start();
            if (k == flip_at) dir = !d;
            chk({req, " R8 no early cascade"}, casc_pin(), 1'b0);
            @(negedge clk);
            pin_l_in = 1'b0; pin_r_in = 1'b0;
        end
        rand_data();
        chk({req, " R8 cascade low at final capture"}, casc_pin(), 1'b0);
        if (done_start) pulse_start();
        @(negedge clk);
        pin_l_in = 1'b0; pin_r_in = 1'b0;
        chk({req, " R8 cascade high"}, casc_pin(), 1'b1);
        @(negedge clk);
        chk({req, " R8 cascade one cycle"}, casc_pin(), 1'b0);
    endtask

    task automatic idle_watch(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            rand_data();
            @(negedge clk);
            chk(req, {pin_l_out, pin_r_out}, 2'b00);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; dir = 1'b1; pin_l_in = 1'b0; pin_r_in = 1'b0; rd_pos = '0;
        rand_data();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R7 reset state and pin roles
        chk("R1 pins low after reset", {pin_l_out, pin_r_out}, 2'b00);
        chk("R7 dir=1 enables", {pin_l_oe, pin_r_oe}, 2'b01);
        dir = 1'b0; #1;
        chk("R7 dir=0 enables", {pin_l_oe, pin_r_oe}, 2'b10);
        dir = 1'b1;
        idle_watch(5, "R1 no activity without start");
        @(negedge clk);

        // R3 R4 R6 ascending sweep
        run_sweep(1'b1, -1, -1, 1'b0, "R3 R4");
        check_mem("R4 R6 R2 ascending contents");

        // R5 descending sweep with ignored start pulses (R9)
        run_sweep(1'b0, -1, 10, 1'b1, "R5 R9");
        check_mem("R5 R9 R6 descending contents");

        // R10 idle retention; also confirms the DONE-cycle start was dropped
        idle_watch(70, "R10 R9 no cascade while idle");
        check_mem("R10 memory retained while idle");

        // R11 direction flip mid-sweep
        run_sweep(1'b1, 20, -1, 1'b0, "R11");
        check_mem("R11 latched order kept");

        // R12 reset mid-sweep
        dir = 1'b0;
        pulse_start();
        @(negedge clk);
        pin_l_in = 1'b0; pin_r_in = 1'b0;
        for (int k = 0; k < 10; k++) begin
            rand_data();
            record(1'b0, k);
            @(negedge clk);
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idle_watch(70, "R12 no cascade after abort");
        run_sweep(1'b0, -1, -1, 1'b0, "R12");
        check_mem("R12 restart from first pair");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule